// File: doc/BRIEF.md
# Transmit Backoff Scheduler

This block decides when a queued transmit attempt is allowed to start. Each attempt request supplies the packet's current backoff load, the minimum spacing between packets, and a free-running real-time count in 32 µs units. The block returns an updated load for the caller to store. It then does one of three things: it starts the transmission at once, it waits a computed number of 16 µs ticks and then starts, or it reports that the load has overflowed.

The backoff window is built from the old load. The load gains one more low-order 1 on each attempt, so the window doubles in size each time. This mask is ANDed with the top byte of a 16-bit linear congruential generator, which steps once per accepted attempt. When the masked value is non-zero, it sets the wait. When it is zero, the block compares the time elapsed since the last successful transmission with the minimum spacing, and waits out any shortfall.

Top module: `tx_backoff_sched`

## Requirements
- R1: One cycle after an accepted attempt, `load_wr` is high for one cycle and `load_out` equals the old load shifted left by one with bit 0 set, truncated to 16 bits.
- R2: If bit 15 of the old load is set, `load_ovf` pulses in the cycle where `load_wr` pulses, `go` stays low, and no wait is started.
- R3: The generator starts at 16'h0001 after reset and steps as R ← (R·2053 + 13849) mod 65536 once per accepted attempt, overflow attempts included. The random byte is bits 15:8 of the stepped value.
- R4: Let M = (old load bits 7:0) AND (random byte). If M ≠ 0, `go` pulses in the cycle after the edge that samples the (2·M)-th high `tick16`. Cycles in which `tick16` is low are not counted.
- R5: If M = 0 and E ≥ `min_gap`, `go` pulses in the same cycle as `load_wr`. E is (`rt_count` − recorded end time) mod 65536, sampled with the attempt.
- R6: If M = 0 and E < `min_gap`, the wait is 2·(`min_gap` − E) ticks, counted as in R4.
- R7: A `pkt_done` pulse records `rt_count` as the end time. The end time is 0 after reset.
- R8: An attempt request raised while a wait is in progress is ignored: no `load_wr` pulse, no generator step, and the running wait keeps its length.
- R9: `go` and `load_ovf` are single-cycle pulses and are never high together.
- R10: During and right after reset, `go`, `load_ovf` and `load_wr` are low and `load_out` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| attempt_req | input | 1 | Request a transmit decision (accepted when idle) |
| load_in | input | 16 | Current backoff load of the packet |
| min_gap | input | 16 | Minimum inter-packet spacing, 32 µs units |
| rt_count | input | 16 | Real-time counter, 32 µs units |
| tick16 | input | 1 | One-cycle pulse every 16 µs |
| pkt_done | input | 1 | Previous packet completed successfully |
| load_out | output | 16 | Updated load to be stored |
| load_wr | output | 1 | `load_out` is valid this cycle |
| go | output | 1 | Transmission may start |
| load_ovf | output | 1 | Attempt rejected, load overflowed |

## Verification
A generator that steps at the wrong time, or from the wrong seed, changes the wait length of the very next attempt whose load exposes the random byte, so the `go` pulse appears on the wrong tick. A stale or wrongly captured end time shows up as a wrong wait on the first zero-backoff attempt that has a non-zero minimum gap. A wait counter that counts idle cycles, or that reloads on an ignored request, moves `go` within the same attempt. A wrong shift or overflow test shows in `load_out` and `load_ovf` one cycle after the request.

// File: rtl/tbs_pkg.sv
package tbs_pkg;
  typedef enum logic [0:0] {
    TBS_IDLE = 1'b0,
    TBS_WAIT = 1'b1
  } tbs_state_e;
endpackage

// File: rtl/tbs_lcg.sv
// Linear congruential generator: state steps by state*MUL + INC.
module tbs_lcg #(
  parameter int GEN_W    = 16,
  parameter int GEN_MUL  = 2053,
  parameter int GEN_INC  = 13849,
  parameter int GEN_SEED = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [GEN_W-1:0] next_val
);
  localparam logic [GEN_W-1:0] MulV  = GEN_W'(GEN_MUL);
  localparam logic [GEN_W-1:0] IncV  = GEN_W'(GEN_INC);
  localparam logic [GEN_W-1:0] SeedV = GEN_W'(GEN_SEED);

  logic [GEN_W-1:0] state_q;
  logic [GEN_W-1:0] state_d;

  always_comb begin
    next_val = state_q * MulV + IncV;
    state_d  = state_q;
    if (step) begin
      state_d = next_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SeedV;
    end else begin
      state_q <= state_d;
    end
  end
endmodule

// File: rtl/tbs_delay_calc.sv
// Wait length in fine ticks: the masked backoff, or the gap shortfall.
module tbs_delay_calc #(
  parameter int LOAD_W = 16,
  parameter int RAND_W = 8,
  parameter int TIME_W = 16,
  parameter int CNT_W  = TIME_W + 1
) (
  input  logic [LOAD_W-1:0] load_old,
  input  logic [RAND_W-1:0] rnd,
  input  logic [TIME_W-1:0] min_gap,
  input  logic [TIME_W-1:0] rt_now,
  input  logic [TIME_W-1:0] end_time,
  output logic [CNT_W-1:0]  wait_ticks
);
  localparam int PadBk  = CNT_W - RAND_W - 1;
  localparam int PadGap = CNT_W - TIME_W - 1;

  logic [RAND_W-1:0] masked;
  logic [TIME_W-1:0] elapsed;
  logic [TIME_W-1:0] remain;
  logic              short_gap;

  always_comb begin
    masked    = load_old[RAND_W-1:0] & rnd;
    elapsed   = rt_now - end_time;
    short_gap = elapsed < min_gap;
    remain    = min_gap - elapsed;
    if (masked != '0) begin
      wait_ticks = {{PadBk{1'b0}}, masked, 1'b0};
    end else if (short_gap) begin
      wait_ticks = {{PadGap{1'b0}}, remain, 1'b0};
    end else begin
      wait_ticks = '0;
    end
  end
endmodule

// File: rtl/tbs_tick_ctr.sv
// Down-counter advanced only on tick pulses; flags the final tick.
module tbs_tick_ctr #(
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  localparam logic [CNT_W-1:0] One = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             active;

  always_comb begin
    active = cnt_q != '0;
    expire = active && tick && (cnt_q == One);
    cnt_d  = cnt_q;
    if (load_en) begin
      cnt_d = load_val;
    end else if (active && tick) begin
      cnt_d = cnt_q - One;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/tx_backoff_sched.sv
module tx_backoff_sched #(
  parameter int LOAD_W   = 16,
  parameter int TIME_W   = 16,
  parameter int GEN_W    = 16,
  parameter int RAND_W   = 8,
  parameter int GEN_MUL  = 2053,
  parameter int GEN_INC  = 13849,
  parameter int GEN_SEED = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              attempt_req,
  input  logic [LOAD_W-1:0] load_in,
  input  logic [TIME_W-1:0] min_gap,
  input  logic [TIME_W-1:0] rt_count,
  input  logic              tick16,
  input  logic              pkt_done,
  output logic [LOAD_W-1:0] load_out,
  output logic              load_wr,
  output logic              go,
  output logic              load_ovf
);
  import tbs_pkg::*;

  localparam int CNT_W = TIME_W + 1;

  tbs_state_e        state_q, state_d;
  logic [TIME_W-1:0] end_q, end_d;
  logic [LOAD_W-1:0] load_q, load_d;
  logic              wr_q, wr_d;
  logic              go_q, go_d;
  logic              ovf_q, ovf_d;

  logic              accept;
  logic              ctr_load;
  logic              expire;
  logic [GEN_W-1:0]  gen_next;
  logic [RAND_W-1:0] rnd;
  logic [CNT_W-1:0]  wait_ticks;

  assign accept = attempt_req && (state_q == TBS_IDLE);
  assign rnd    = gen_next[GEN_W-1 -: RAND_W];

  tbs_lcg #(
    .GEN_W    (GEN_W),
    .GEN_MUL  (GEN_MUL),
    .GEN_INC  (GEN_INC),
    .GEN_SEED (GEN_SEED)
  ) u_lcg (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (accept),
    .next_val (gen_next)
  );

  tbs_delay_calc #(
    .LOAD_W (LOAD_W),
    .RAND_W (RAND_W),
    .TIME_W (TIME_W),
    .CNT_W  (CNT_W)
  ) u_calc (
    .load_old   (load_in),
    .rnd        (rnd),
    .min_gap    (min_gap),
    .rt_now     (rt_count),
    .end_time   (end_q),
    .wait_ticks (wait_ticks)
  );

  tbs_tick_ctr #(
    .CNT_W (CNT_W)
  ) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (ctr_load),
    .load_val (wait_ticks),
    .tick     (tick16),
    .expire   (expire)
  );

  // Next-state logic
  always_comb begin
    state_d  = state_q;
    load_d   = load_q;
    wr_d     = 1'b0;
    go_d     = 1'b0;
    ovf_d    = 1'b0;
    ctr_load = 1'b0;
    end_d    = end_q;
    if (pkt_done) begin
      end_d = rt_count;
    end
    unique case (state_q)
      TBS_IDLE: begin
        if (accept) begin
          load_d = {load_in[LOAD_W-2:0], 1'b1};
          wr_d   = 1'b1;
          if (load_in[LOAD_W-1]) begin
            ovf_d = 1'b1;
          end else if (wait_ticks == '0) begin
            go_d = 1'b1;
          end else begin
            ctr_load = 1'b1;
            state_d  = TBS_WAIT;
          end
        end
      end
      TBS_WAIT: begin
        if (expire) begin
          go_d    = 1'b1;
          state_d = TBS_IDLE;
        end
      end
      default: state_d = TBS_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TBS_IDLE;
      end_q   <= '0;
      load_q  <= '0;
      wr_q    <= 1'b0;
      go_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      end_q   <= end_d;
      load_q  <= load_d;
      wr_q    <= wr_d;
      go_q    <= go_d;
      ovf_q   <= ovf_d;
    end
  end

  assign load_out = load_q;
  assign load_wr  = wr_q;
  assign go       = go_q;
  assign load_ovf = ovf_q;
endmodule

// File: rtl/tbs_sched_chk.sv
module tbs_sched_chk #(
  parameter int LOAD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              attempt_req,
  input logic [LOAD_W-1:0] load_in,
  input logic [LOAD_W-1:0] load_out,
  input logic              load_wr,
  input logic              go,
  input logic              load_ovf
);
  // R1
  load_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |-> (load_out == {$past(load_in[LOAD_W-2:0]), 1'b1}) && $past(attempt_req));

  // R2
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ovf |-> $past(load_in[LOAD_W-1]) && load_wr);

  // R9
  go_ovf_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(go && load_ovf));

  // R9
  go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

  // R9
  ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_ovf |=> !load_ovf);

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> !go && !load_ovf && !load_wr && (load_out == '0));
endmodule

bind tx_backoff_sched tbs_sched_chk #(.LOAD_W(LOAD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .attempt_req (attempt_req),
  .load_in     (load_in),
  .load_out    (load_out),
  .load_wr     (load_wr),
  .go          (go),
  .load_ovf    (load_ovf)
);

// File: tb/tx_backoff_sched_bench.sv
module tx_backoff_sched_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk;
  logic        rst_n;
  logic        attempt_req;
  logic [15:0] load_in;
  logic [15:0] min_gap;
  logic [15:0] rt_count;
  logic        tick16;
  logic        pkt_done;
  logic [15:0] load_out;
  logic        load_wr;
  logic        go;
  logic        load_ovf;

  int n_chk;
  int n_fail;
  int cycles;
  logic [15:0] bm_r;
  logic [15:0] bm_end;

  tx_backoff_sched u_tx_backoff_sched (
    .clk         (clk),
    .rst_n       (rst_n),
    .attempt_req (attempt_req),
    .load_in     (load_in),
    .min_gap     (min_gap),
    .rt_count    (rt_count),
    .tick16      (tick16),
    .pkt_done    (pkt_done),
    .load_out    (load_out),
    .load_wr     (load_wr),
    .go          (go),
    .load_ovf    (load_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > MAX_CYCLES) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run exceeded %0d cycles (expected completion)", MAX_CYCLES);
        finish_run();
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] gen_step(input logic [15:0] r);
    gen_step = r * 16'd2053 + 16'd13849;
  endfunction

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic mark_done(input logic [15:0] rt);
    rt_count = rt;
    pkt_done = 1'b1;
    cycle();
    pkt_done = 1'b0;
    bm_end = rt;
  endtask

  // One attempt, with its full wait and an ignored request inside the wait.
  task automatic attempt(input logic [15:0] ld, input logic [15:0] mg,
                         input logic [15:0] rt, input string tag);
    logic [7:0]  rnd;
    logic [7:0]  m;
    logic [15:0] el;
    int          n;
    load_in     = ld;
    min_gap     = mg;
    rt_count    = rt;
    attempt_req = 1'b1;
    cycle();
    attempt_req = 1'b0;
    bm_r = gen_step(bm_r);
    rnd  = bm_r[15:8];
    chk(load_wr == 1'b1, "R1 load_wr", int'(load_wr), 1);
    chk(load_out == {ld[14:0], 1'b1}, "R1 load_out", int'(load_out), int'({ld[14:0], 1'b1}));
    if (ld[15]) begin
      chk(load_ovf == 1'b1 && go == 1'b0, "R2 overflow", int'({load_ovf, go}), 2);
      cycle();
      chk(load_ovf == 1'b0 && go == 1'b0, "R9 ovf pulse", int'({load_ovf, go}), 0);
      return;
    end
    chk(load_ovf == 1'b0, "R2 no ovf", int'(load_ovf), 0);
    m  = ld[7:0] & rnd;
    el = rt - bm_end;
    if (m != 8'd0) n = 2 * int'(m);
    else if (el >= mg) n = 0;
    else n = 2 * int'(mg - el);
    if (n == 0) begin
      chk(go == 1'b1, {tag, " R5 immediate go"}, int'(go), 1);
      cycle();
      chk(go == 1'b0, "R9 go pulse", int'(go), 0);
      return;
    end
    chk(go == 1'b0, {tag, " no go before wait"}, int'(go), 0);
    for (int k = 1; k <= n; k++) begin
      tick16 = 1'b1;
      if (k == 1) begin
        attempt_req = 1'b1;
        load_in     = 16'h00FF;
      end
      cycle();
      tick16      = 1'b0;
      if (k == 1) begin
        attempt_req = 1'b0;
        chk(load_wr == 1'b0, "R8 ignored request", int'(load_wr), 0);
      end
      if (k == n) begin
        chk(go == 1'b1, {tag, " go on last tick"}, int'(go), 1);
      end else if (k == 1 || k == n - 1) begin
        chk(go == 1'b0, {tag, " early go"}, int'(go), 0);
      end
      cycle();
      chk(go == 1'b0, {tag, " R4 idle cycle / R9 pulse"}, int'(go), 0);
    end
  endtask

  initial begin
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    attempt_req = 1'b0;
    load_in = '0;
    min_gap = '0;
    rt_count = '0;
    tick16 = 1'b0;
    pkt_done = 1'b0;
    bm_r = 16'h0001;
    bm_end = '0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(go == 1'b0 && load_ovf == 1'b0 && load_wr == 1'b0, "R10 reset outputs",
        int'({go, load_ovf, load_wr}), 0);
    chk(load_out == 16'h0000, "R10 reset load_out", int'(load_out), 0);
    rst_n = 1'b1;
    cycle();
    chk(go == 1'b0 && load_wr == 1'b0, "R10 after release", int'({go, load_wr}), 0);

    // Full random byte exposed: wait length traces the generator (R3, R4)
    for (int i = 0; i < 40; i++) begin
      attempt(16'h00FF, 16'd0, 16'd500, "R3 R4 full mask");
    end

    // Zero backoff: gap check against recorded end times (R5, R6, R7)
    for (int e = 0; e < 3; e++) begin
      logic [15:0] endt;
      endt = (e == 0) ? 16'd40 : ((e == 1) ? 16'hFFFE : 16'h8001);
      mark_done(endt);
      for (int g = 0; g < 6; g++) begin
        for (int d = 0; d < 7; d += 2) begin
          attempt(16'h0000, 16'(g), endt + 16'(d), "R6 R7 gap");
        end
      end
    end

    // Growing load chains up to overflow (R1, R2, R4)
    mark_done(16'd1000);
    for (int c = 0; c < 2; c++) begin
      logic [15:0] ld;
      ld = 16'h0000;
      for (int a = 0; a < 17; a++) begin
        attempt(ld, 16'd3, 16'd2000, "R4 chain");
        ld = {ld[14:0], 1'b1};
      end
    end

    // Generator still in step after all the ignored requests (R3, R8)
    for (int i = 0; i < 10; i++) begin
      attempt(16'h00FF, 16'd0, 16'd3000, "R3 R8 resync");
    end

    finish_run();
  end
endmodule